// File: doc/BRIEF.md
# PWM Time-Base Counter

This block is the timing core of a pulse-width modulation channel. A 16-bit counter steps once per prescaled tick. It runs upward, downward or in a triangle between zero and a programmable period, or it stays frozen. Each time the counter arrives at zero, at the period or at one of two compare values, the block raises a one-cycle strobe. A direction flag shows whether the last step went up or down. A downstream action stage uses these strobes and the flag to shape the output edges.

Software programs the block through a write-only register port. The port holds a control word, the period and two compare values. The control word selects the counting mode and the tick prescale. The prescale is the product of a high-speed divider (1, 2, 4, ... 14) and a binary divider (1 to 128). The control word also chooses how a period write lands. It either goes into a holding copy that becomes active only when the counter next reaches zero, or it takes effect at once.

Top module: `pwm_timebase`

## Requirements
- R1: After reset the count is 0, every strobe and the direction flag are 0, and the mode is frozen. The count stays 0 until the mode is changed.
- R2: The tick divide ratio is H·2^C. H is 1 when the code in control bits 9:7 is 0, and twice that code otherwise. C is the code in control bits 12:10. `baseTick` is high for one cycle in every ratio cycles. The count advances only on edges where `baseTick` is high.
- R3: A control write whose divider codes differ from the current ones clears the prescaler phase, so the next tick comes a full ratio after that write. A control write with unchanged codes leaves the tick phase alone.
- R4: Mode 0 in control bits 1:0 counts up. On each tick the count goes from the period value to 0, and otherwise rises by 1.
- R5: Mode 1 counts down. On each tick the count goes from 0 to the period value, and otherwise falls by 1.
- R6: Mode 2 counts up-down. The count rises to the period value, then falls to 0, then rises again. Neither end value is repeated.
- R7: Mode 3 freezes the count. No tick moves it, and no strobe is raised.
- R8: `zeroHit` and `periodHit` are high for exactly the cycle after the tick edge on which the count arrives at 0 or at the active period.
- R9: `cmpAHit` and `cmpBHit` are high for the cycle after a tick edge on which an upward step lands on compare A (offset 0x12) or compare B (offset 0x14). A downward step never raises them.
- R10: When control bit 3 is 0, a write to the period (offset 0x0A) goes to a holding copy. That copy becomes the active period on the tick edge that brings the count to 0.
- R11: When control bit 3 is 1, a write to the period becomes the active period on the write edge.
- R12: `countDown` is 1 when the step that produced the current count was downward, and 0 when it was upward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 5 | Register byte offset (0x00 control, 0x0A period, 0x12 compare A, 0x14 compare B) |
| wrData | input | 16 | Register write data |
| count | output | 16 | Current counter value |
| countDown | output | 1 | Direction of the last counter step (1 = down) |
| zeroHit | output | 1 | Count arrived at 0 |
| periodHit | output | 1 | Count arrived at the active period |
| cmpAHit | output | 1 | Upward step arrived at compare A |
| cmpBHit | output | 1 | Upward step arrived at compare B |
| baseTick | output | 1 | Prescaled tick enable |

## Verification
Each counting mode runs with small periods, and the exact count and strobe sequence is followed over several periods. The up and down runs tell the two wrap points apart. The triangle run shows that compare strobes fire only on rising steps, and shows the direction flag at both ends. The prescaler runs at ratios 12 and 4. One control rewrite changes the codes and one keeps them, which separates a restart from an undisturbed phase. The period is then rewritten in the middle of a count in each load style. A period strobe at the old value, followed by a later switch at zero, marks the held write. An immediate cut-short marks the direct write.

// File: rtl/pwm_tb_pkg.sv
package pwm_tb_pkg;

  // Control word field positions (decoded by the control stage)
  localparam int MODE_LSB = 0;
  localparam int IMM_BIT  = 3;
  localparam int HS_LSB   = 7;
  localparam int CK_LSB   = 10;

  typedef enum logic [1:0] {
    MODE_UP     = 2'd0,
    MODE_DOWN   = 2'd1,
    MODE_UPDOWN = 2'd2,
    MODE_HOLD   = 2'd3
  } cntMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic     tick;
    logic     prdWrImm;
    cntMode_e mode;
  } tbCtl_t;

endpackage

// File: rtl/pwm_tb_prescaler.sv
module pwm_tb_prescaler #(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] hsCode,
  input  logic [CODE_W-1:0] ckCode,
  input  logic              restart,
  output logic              tick
);
  localparam int HS_MAX    = 2 * ((1 << CODE_W) - 1);
  localparam int MAX_RATIO = HS_MAX << ((1 << CODE_W) - 1);
  localparam int PS_W      = $clog2(MAX_RATIO + 1);

  logic [PS_W-1:0] hsDiv;
  logic [PS_W-1:0] ratio;
  logic [PS_W-1:0] phase;

  always_comb begin
    hsDiv = (hsCode == '0) ? PS_W'(1) : PS_W'({hsCode, 1'b0});
    ratio = hsDiv << ckCode;
  end

  assign tick = (phase == ratio - PS_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= '0;
    end else if (restart || tick) begin
      phase <= '0;
    end else begin
      phase <= phase + PS_W'(1);
    end
  end

endmodule

// File: rtl/pwm_tb_ctrl.sv
module pwm_tb_ctrl
  import pwm_tb_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 5,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output tbCtl_t            ctl,
  output logic [DATA_W-1:0] shadowPrd,
  output logic [DATA_W-1:0] cmpA,
  output logic [DATA_W-1:0] cmpB
);
  localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] OFS_PRD  = ADDR_W'(8'h0A);
  localparam logic [ADDR_W-1:0] OFS_CMPA = ADDR_W'(8'h12);
  localparam logic [ADDR_W-1:0] OFS_CMPB = ADDR_W'(8'h14);

  cntMode_e          modeQ;
  logic              immQ;
  logic [CODE_W-1:0] hsQ;
  logic [CODE_W-1:0] ckQ;

  logic              selCtrl;
  logic              selPrd;
  logic [CODE_W-1:0] hsIn;
  logic [CODE_W-1:0] ckIn;
  logic              restart;
  logic              tick;

  assign selCtrl = wrEn && (wrAddr == OFS_CTRL);
  assign selPrd  = wrEn && (wrAddr == OFS_PRD);
  assign hsIn    = wrData[HS_LSB +: CODE_W];
  assign ckIn    = wrData[CK_LSB +: CODE_W];
  assign restart = selCtrl && ((hsIn != hsQ) || (ckIn != ckQ));

  pwm_tb_prescaler #(.CODE_W(CODE_W)) i_prescaler (
    .clk     (clk),
    .rstN    (rstN),
    .hsCode  (hsQ),
    .ckCode  (ckQ),
    .restart (restart),
    .tick    (tick)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ     <= MODE_HOLD;
      immQ      <= 1'b0;
      hsQ       <= '0;
      ckQ       <= '0;
      shadowPrd <= '0;
      cmpA      <= '0;
      cmpB      <= '0;
    end else if (wrEn) begin
      if (selCtrl) begin
        modeQ <= cntMode_e'(wrData[MODE_LSB +: 2]);
        immQ  <= wrData[IMM_BIT];
        hsQ   <= hsIn;
        ckQ   <= ckIn;
      end
      if (selPrd)                 shadowPrd <= wrData;
      if (wrAddr == OFS_CMPA)     cmpA      <= wrData;
      if (wrAddr == OFS_CMPB)     cmpB      <= wrData;
    end
  end

  always_comb begin
    ctl.tick     = tick;
    ctl.prdWrImm = selPrd && immQ;
    ctl.mode     = modeQ;
  end

endmodule

// File: rtl/pwm_tb_datapath.sv
module pwm_tb_datapath
  import pwm_tb_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  tbCtl_t            ctl,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] shadowPrd,
  input  logic [DATA_W-1:0] cmpA,
  input  logic [DATA_W-1:0] cmpB,
  output logic [DATA_W-1:0] count,
  output logic [DATA_W-1:0] activePrd,
  output logic              countDown,
  output logic              zeroHit,
  output logic              periodHit,
  output logic              cmpAHit,
  output logic              cmpBHit
);
  logic [DATA_W-1:0] nextCnt;
  logic              nextDown;
  logic              advance;
  logic              arriveZero;
  logic [DATA_W-1:0] prdNew;

  always_comb begin
    nextCnt  = count;
    nextDown = countDown;
    unique case (ctl.mode)
      MODE_UP: begin
        nextDown = 1'b0;
        nextCnt  = (count >= activePrd) ? '0 : count + 1'b1;
      end
      MODE_DOWN: begin
        nextDown = 1'b1;
        nextCnt  = (count == '0) ? activePrd : count - 1'b1;
      end
      MODE_UPDOWN: begin
        if (countDown) begin
          if (count == '0) begin
            nextDown = 1'b0;
            nextCnt  = (activePrd == '0) ? '0 : DATA_W'(1);
          end else begin
            nextCnt  = count - 1'b1;
          end
        end else begin
          if (count >= activePrd) begin
            nextDown = 1'b1;
            nextCnt  = (count == '0) ? '0 : count - 1'b1;
          end else begin
            nextCnt  = count + 1'b1;
          end
        end
      end
      default: begin
        nextCnt  = count;
        nextDown = countDown;
      end
    endcase
    advance    = ctl.tick && (ctl.mode != MODE_HOLD);
    arriveZero = advance && (nextCnt == '0);
    if (ctl.prdWrImm)  prdNew = wrData;
    else if (arriveZero) prdNew = shadowPrd;
    else               prdNew = activePrd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count     <= '0;
      countDown <= 1'b0;
      activePrd <= '0;
      zeroHit   <= 1'b0;
      periodHit <= 1'b0;
      cmpAHit   <= 1'b0;
      cmpBHit   <= 1'b0;
    end else begin
      activePrd <= prdNew;
      zeroHit   <= arriveZero;
      periodHit <= advance && (nextCnt == prdNew);
      cmpAHit   <= advance && !nextDown && (nextCnt == cmpA);
      cmpBHit   <= advance && !nextDown && (nextCnt == cmpB);
      if (advance) begin
        count     <= nextCnt;
        countDown <= nextDown;
      end
    end
  end

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_tb_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 5,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] count,
  output logic              countDown,
  output logic              zeroHit,
  output logic              periodHit,
  output logic              cmpAHit,
  output logic              cmpBHit,
  output logic              baseTick
);
  tbCtl_t            ctl;
  logic [DATA_W-1:0] shadowPrd;
  logic [DATA_W-1:0] cmpAVal;
  logic [DATA_W-1:0] cmpBVal;
  logic [DATA_W-1:0] activePrd;

  pwm_tb_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CODE_W(CODE_W)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .ctl       (ctl),
    .shadowPrd (shadowPrd),
    .cmpA      (cmpAVal),
    .cmpB      (cmpBVal)
  );

  pwm_tb_datapath #(.DATA_W(DATA_W)) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .wrData    (wrData),
    .shadowPrd (shadowPrd),
    .cmpA      (cmpAVal),
    .cmpB      (cmpBVal),
    .count     (count),
    .activePrd (activePrd),
    .countDown (countDown),
    .zeroHit   (zeroHit),
    .periodHit (periodHit),
    .cmpAHit   (cmpAHit),
    .cmpBHit   (cmpBHit)
  );

  assign baseTick = ctl.tick;

endmodule

// File: rtl/pwm_timebase_chk.sv
module pwm_timebase_chk
  import pwm_tb_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input cntMode_e          mode,
  input logic              baseTick,
  input logic [DATA_W-1:0] count,
  input logic [DATA_W-1:0] activePrd,
  input logic [DATA_W-1:0] cmpAVal,
  input logic [DATA_W-1:0] cmpBVal,
  input logic              countDown,
  input logic              zeroHit,
  input logic              periodHit,
  input logic              cmpAHit,
  input logic              cmpBHit
);

  p_zero_after_tick_r8: assert property (@(posedge clk) disable iff (!rstN)
    zeroHit |-> ($past(baseTick) && count == '0));

  p_period_value_r8: assert property (@(posedge clk) disable iff (!rstN)
    periodHit |-> (count == activePrd));

  p_cmpa_rising_r9: assert property (@(posedge clk) disable iff (!rstN)
    cmpAHit |-> (!countDown && count == $past(cmpAVal)));

  p_cmpb_rising_r9: assert property (@(posedge clk) disable iff (!rstN)
    cmpBHit |-> (!countDown && count == $past(cmpBVal)));

  p_frozen_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_HOLD) |=> ($stable(count) && !zeroHit && !periodHit));

  p_up_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_UP && baseTick && count < activePrd)
      |=> (count == DATA_W'($past(count) + 1'b1)));

  p_no_tick_no_move_r2: assert property (@(posedge clk) disable iff (!rstN)
    !baseTick |=> $stable(count));

endmodule

bind pwm_timebase pwm_timebase_chk #(.DATA_W(DATA_W)) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .mode      (ctl.mode),
  .baseTick  (baseTick),
  .count     (count),
  .activePrd (activePrd),
  .cmpAVal   (cmpAVal),
  .cmpBVal   (cmpBVal),
  .countDown (countDown),
  .zeroHit   (zeroHit),
  .periodHit (periodHit),
  .cmpAHit   (cmpAHit),
  .cmpBHit   (cmpBHit)
);

// File: tb/test_pwm_timebase.sv
module test_pwm_timebase;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] A_CTRL = 5'h00;
  localparam logic [4:0] A_PRD  = 5'h0A;
  localparam logic [4:0] A_CMPA = 5'h12;
  localparam logic [4:0] A_CMPB = 5'h14;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [4:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] count;
  logic        countDown, zeroHit, periodHit, cmpAHit, cmpBHit, baseTick;

  int checks = 0;
  int fails  = 0;

  pwm_timebase i_pwm_timebase (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .count(count), .countDown(countDown), .zeroHit(zeroHit),
    .periodHit(periodHit), .cmpAHit(cmpAHit), .cmpBHit(cmpBHit),
    .baseTick(baseTick)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    wrEn = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  // called at a negedge; the write lands on the next posedge
  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic testReset();
    doReset();
    check("R1", "count", count, 0);
    check("R1", "zeroHit", zeroHit, 0);
    check("R1", "periodHit", periodHit, 0);
    check("R1", "cmpHits", {cmpAHit, cmpBHit}, 0);
    check("R1", "countDown", countDown, 0);
    check("R2", "baseTick at ratio 1", baseTick, 1);
    repeat (4) @(negedge clk);
    check("R1", "count still frozen", count, 0);
  endtask

  task automatic testUp();
    doReset();
    wr(A_CTRL, 16'h000B);
    wr(A_PRD, 16'd4);
    wr(A_CMPA, 16'd2);
    wr(A_CMPB, 16'd3);
    wr(A_CTRL, 16'h0008);
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      check("R4", "up count", count, k % 5);
      check("R8", "up zeroHit", zeroHit, int'(k % 5 == 0));
      check("R8", "up periodHit", periodHit, int'(k % 5 == 4));
      check("R9", "up cmpAHit", cmpAHit, int'(k % 5 == 2));
      check("R9", "up cmpBHit", cmpBHit, int'(k % 5 == 3));
      check("R12", "up dir", countDown, 0);
    end
  endtask

  task automatic testDown();
    doReset();
    wr(A_CTRL, 16'h000B);
    wr(A_PRD, 16'd3);
    wr(A_CMPA, 16'd1);
    wr(A_CTRL, 16'h0009);
    for (int k = 1; k <= 9; k++) begin
      @(negedge clk);
      check("R5", "down count", count, (4 - (k % 4)) % 4);
      check("R8", "down zeroHit", zeroHit, int'(k % 4 == 0));
      check("R8", "down periodHit", periodHit, int'(k % 4 == 1));
      check("R9", "down cmpHits", {cmpAHit, cmpBHit}, 0);
      check("R12", "down dir", countDown, 1);
    end
  endtask

  task automatic testUpDown();
    doReset();
    wr(A_CTRL, 16'h000B);
    wr(A_PRD, 16'd3);
    wr(A_CMPA, 16'd2);
    wr(A_CTRL, 16'h000A);
    for (int k = 1; k <= 14; k++) begin
      int m;
      @(negedge clk);
      m = k % 6;
      check("R6", "updown count", count, (m <= 3) ? m : 6 - m);
      check("R12", "updown dir", countDown, int'(m >= 4 || m == 0));
      check("R9", "updown cmpAHit", cmpAHit, int'(m == 2));
      check("R8", "updown periodHit", periodHit, int'(m == 3));
      check("R8", "updown zeroHit", zeroHit, int'(m == 0));
    end
  endtask

  task automatic testFreeze();
    doReset();
    wr(A_CTRL, 16'h000B);
    wr(A_PRD, 16'd9);
    wr(A_CTRL, 16'h0008);
    repeat (3) @(negedge clk);
    wr(A_CTRL, 16'h000B);
    check("R7", "count at freeze", count, 4);
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      check("R7", "frozen count", count, 4);
      check("R7", "frozen strobes", {zeroHit, periodHit, cmpAHit, cmpBHit}, 0);
    end
  endtask

  task automatic testPrescale();
    doReset();
    wr(A_CTRL, 16'h000B);
    wr(A_PRD, 16'd100);
    wr(A_CTRL, 16'h0588);   // H code 3 -> 6, C code 1 -> 2, ratio 12
    for (int k = 1; k <= 36; k++) begin
      @(negedge clk);
      check("R2", "tick ratio 12", baseTick, int'(k % 12 == 11));
      check("R2", "count per tick", count, k / 12);
    end
    repeat (4) @(negedge clk);
    wr(A_CTRL, 16'h0808);   // H code 0, C code 2 -> ratio 4, restart
    for (int k = 1; k <= 9; k++) begin
      @(negedge clk);
      check("R3", "tick after restart", baseTick, int'(k % 4 == 3));
      check("R3", "count after restart", count, 3 + k / 4);
    end
    wr(A_CTRL, 16'h0809);   // same codes, down mode: no restart
    check("R3", "tick no restart", baseTick, 0);
    for (int k = 11; k <= 16; k++) begin
      @(negedge clk);
      check("R3", "tick phase kept", baseTick, int'(k % 4 == 3));
      if (k == 12) check("R5", "down step from 5", count, 4);
    end
  endtask

  task automatic testShadow();
    doReset();
    wr(A_CTRL, 16'h000B);
    wr(A_PRD, 16'd2);
    wr(A_CTRL, 16'h0000);
    @(negedge clk);
    check("R10", "shadow start", count, 1);
    wr(A_PRD, 16'd5);
    check("R10", "old period still active", count, 2);
    check("R10", "old periodHit", periodHit, 1);
    for (int k = 3; k <= 9; k++) begin
      @(negedge clk);
      check("R10", "count with new period", count, (k - 3) % 6);
      check("R10", "periodHit new period", periodHit, int'(k == 8));
      check("R8", "zeroHit shadow", zeroHit, int'(k == 3 || k == 9));
    end
  endtask

  task automatic testImmediate();
    doReset();
    wr(A_CTRL, 16'h000B);
    wr(A_PRD, 16'd6);
    wr(A_CTRL, 16'h0008);
    @(negedge clk);
    @(negedge clk);
    check("R11", "count before write", count, 2);
    wr(A_PRD, 16'd3);
    check("R11", "count at new period", count, 3);
    check("R11", "periodHit at once", periodHit, 1);
    @(negedge clk);
    check("R11", "wrap at new period", count, 0);
    check("R11", "zeroHit after wrap", zeroHit, 1);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    testReset();
    testUp();
    testDown();
    testUpDown();
    testFreeze();
    testPrescale();
    testShadow();
    testImmediate();
    finishRun();
  end

endmodule